// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The controller watches 40 external input lines and turns qualifying transitions on them into interrupt requests for a downstream interrupt controller. Lines 0 to 31 form the low bank and lines 32 to 39 the high bank. Each line carries an interrupt mask bit, an event mask bit, rising and falling edge selects, a software trigger bit and a pending flag. All of these are reached through a simple 32-bit register port with a write strobe and a combinational read.

Inputs are registered once, and an edge is found by comparing that sample with the one before it. When an unmasked line sees a selected edge, or software raises its trigger bit from 0 to 1 while the line is unmasked, the line's pending flag is set. Each newly set pending flag emits a one-cycle pulse on its interrupt output. Lines 5 to 9 share a single output. Software clears a pending flag by writing 1 to it. The downstream controller latches each pulse, so clearing a flag never withdraws a request that was already delivered. Some lines are direct lines: their edge select, software trigger and pending bits are fixed at zero.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: Byte offsets within a bank are 0x00 interrupt mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger and 0x14 pending. The high bank adds 0x20 to each offset. In the low bank, both mask registers keep all 32 bits and both select registers keep only the bits in 0x007DFFFF. In the high bank, both mask registers keep bits 7:0 and both select registers keep only the bits in 0x78. Every other bit reads zero.
- R3: Direct lines are low-bank bits 17 and 31:23 and high-bank bits 0, 1, 2 and 7. Writes to these bits in the select, software trigger and pending registers have no effect, and the bits read zero. An edge on a direct line never pends it.
- R4: An unmasked line becomes pending when its input rises with the rising select set, or falls with the falling select set. With both selects set, either edge pends it. The interrupt pulse appears two cycles after the input changes.
- R5: With neither select bit set, no edge pends the line or produces a pulse.
- R6: An edge that arrives while the line is masked is dropped. Unmasking the line later does not pend it.
- R7: Writing 1 to a software trigger bit that holds 0, while the line is unmasked, sets the line's pending flag. The pulse appears in the cycle after the write, and the trigger bit reads 1.
- R8: A software trigger bit written while the line is masked reads 1 but does not pend the line. Unmasking the line later does not pend it either.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Clearing a pending bit also clears the matching software trigger bit. A clear produces no pulse.
- R10: A pulse lasts exactly one cycle and is emitted only when a pending flag goes from clear to set. A new trigger on a line that is already pending emits no pulse.
- R11: Output mapping: output k carries line k for k below 5. Output 5 is the OR of lines 5 to 9, giving one pulse even when several of those lines pend together. Output k carries line k+4 for k from 6 to 35.
- R12: If a pending clear and a new pend of the same line fall in the same cycle, the line stays pending and a pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 40 | External input lines, already synchronous to clk |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte address; bit 5 selects the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 36 | One-cycle interrupt pulses, mapped as in R11 |

## Verification
Reads are combinational, so a read check is due in the same cycle that the address is driven. A register write becomes visible in the next cycle. A software trigger pulses one cycle after its write. An input change pulses two cycles after it is driven: one cycle for the sample register and one for the pending register. The driver tags every expected item with the exact cycle in which it is due. The monitor samples each cycle a quarter period after the falling edge and compares only the items due in that cycle. In any cycle where no pulse is expected, a nonzero output is reported as a stray pulse, which is how the absence of pulses is checked.

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int HI_LINES = 8,
  parameter logic [31:0] LO_EDGE_MASK = 32'h007D_FFFF,
  parameter logic [HI_LINES-1:0] HI_EDGE_MASK = 8'h78,
  parameter int SHARE_LO = 5,
  parameter int SHARE_HI = 9,
  localparam int NL = 32 + HI_LINES,
  localparam int NOUT = NL - (SHARE_HI - SHARE_LO)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   line_i,
  input  logic            bus_we,
  input  logic [5:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NOUT-1:0] irq_o
);
  localparam logic [NL-1:0] EDGE_MSK = {HI_EDGE_MASK, LO_EDGE_MASK};
  localparam int F_IMR = 0, F_EMR = 1, F_RSE = 2, F_FSE = 3, F_SWT = 4, F_PND = 5;

  logic [NL-1:0] imr, emr, rsel, fsel, swt, pnd;
  logic [NL-1:0] smp, smp_q, pulse;
  logic [NL-1:0] bank, wvec, sw_hit, edge_hit, clr, set_v;
  logic [NL-1:0] rsel40;
  logic [2:0]    fld;
  logic [7:0]    wr_f;

  assign fld  = bus_addr[4:2];
  assign wr_f = {7'b0, bus_we && (bus_addr[1:0] == 2'b00)} << fld;
  assign bank = bus_addr[5] ? {{HI_LINES{1'b1}}, 32'b0} : {{HI_LINES{1'b0}}, {32{1'b1}}};
  assign wvec = bus_addr[5] ? {bus_wdata[HI_LINES-1:0], 32'b0} : {{HI_LINES{1'b0}}, bus_wdata};

  assign sw_hit   = wr_f[F_SWT] ? (wvec & EDGE_MSK & ~swt & imr) : '0;
  assign edge_hit = imr & ((rsel & smp & ~smp_q) | (fsel & ~smp & smp_q));
  assign clr      = wr_f[F_PND] ? (wvec & EDGE_MSK) : '0;
  assign set_v    = sw_hit | edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr <= '0; emr <= '0; rsel <= '0; fsel <= '0; swt <= '0; pnd <= '0;
      smp <= '0; smp_q <= '0; pulse <= '0;
    end else begin
      smp   <= line_i;
      smp_q <= smp;
      if (wr_f[F_IMR]) imr  <= (imr & ~bank) | wvec;
      if (wr_f[F_EMR]) emr  <= (emr & ~bank) | wvec;
      if (wr_f[F_RSE]) rsel <= (rsel & ~bank) | (wvec & EDGE_MSK);
      if (wr_f[F_FSE]) fsel <= (fsel & ~bank) | (wvec & EDGE_MSK);
      swt   <= wr_f[F_SWT] ? ((swt & ~bank) | (wvec & EDGE_MSK)) : (swt & ~clr);
      pnd   <= (pnd & ~clr) | set_v;
      pulse <= set_v & ~(pnd & ~clr);
    end
  end

  always_comb begin
    case (fld)
      3'd0:    rsel40 = imr;
      3'd1:    rsel40 = emr;
      3'd2:    rsel40 = rsel;
      3'd3:    rsel40 = fsel;
      3'd4:    rsel40 = swt;
      3'd5:    rsel40 = pnd;
      default: rsel40 = '0;
    endcase
    bus_rdata = bus_addr[5] ? 32'(rsel40[NL-1:32]) : rsel40[31:0];
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    if (i < SHARE_LO) begin : g_own
      assign irq_o[i] = pulse[i];
    end else if (i == SHARE_LO) begin : g_shared
      assign irq_o[i] = |pulse[SHARE_HI:SHARE_LO];
    end else begin : g_upper
      assign irq_o[i] = pulse[i + SHARE_HI - SHARE_LO];
    end
  end
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int NL = 40,
  parameter int NOUT = 36,
  parameter logic [NL-1:0] EDGE_MSK = '0,
  parameter logic [31:0] LO_SEL_MASK = 32'h007D_FFFF
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [NOUT-1:0] irq_o,
  input logic [NL-1:0]   imr,
  input logic [NL-1:0]   rsel,
  input logic [NL-1:0]   fsel,
  input logic [NL-1:0]   swt,
  input logic [NL-1:0]   pnd
);
  AST_LO_RISE_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 6'h08) |-> ((bus_rdata & ~LO_SEL_MASK) == 32'h0)); // R2
  AST_DIRECT_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (((pnd | swt | rsel | fsel) & ~EDGE_MSK) == '0)); // R3
  AST_PEND_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pnd & ~$past(pnd) & ~$past(imr)) == '0)); // R6
  AST_CLEAR_DROPS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pnd & $past(pnd) & swt) == '0)); // R9
  AST_PULSE_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |-> pnd[0]); // R10
  AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |=> !irq_o[0]); // R10
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NL(NL), .NOUT(NOUT), .EDGE_MSK(EDGE_MSK), .LO_SEL_MASK(LO_EDGE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .imr(imr), .rsel(rsel), .fsel(fsel), .swt(swt), .pnd(pnd)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb_top;
  localparam int PER = 10;
  localparam int NL = 40;
  localparam int NOUT = 36;

  typedef struct {
    int          cyc;
    bit          is_irq;
    logic [63:0] val;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NL-1:0] line_i = '0;
  logic [NOUT-1:0] irq_o;

  item_t sbq[$];
  int slot = 0, cur = 0, checks = 0, errors = 0;

  xirq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #(PER/2) clk = ~clk;

  task automatic push(int dly, bit is_irq, logic [63:0] v, string tag);
    item_t it;
    it.cyc = cur + dly; it.is_irq = is_irq; it.val = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d; cur = slot + 1;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    @(negedge clk); bus_we = 0; bus_addr = a; cur = slot + 1;
    push(0, 0, {32'b0, e}, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_we = 0; cur = slot + 1;
    end
  endtask

  task automatic drive(logic [NL-1:0] v);
    @(negedge clk); bus_we = 0; line_i = v; cur = slot + 1;
  endtask

  always begin
    bit got_irq;
    @(negedge clk); #(PER/4);
    slot++;
    if (rst_n) begin
      got_irq = 0;
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].cyc == slot) begin
          checks++;
          if (sbq[i].is_irq) begin
            got_irq = 1;
            if (irq_o !== sbq[i].val[NOUT-1:0]) begin
              errors++;
              $display("FAIL %s irq slot %0d actual=%h expected=%h", sbq[i].tag, slot, irq_o, sbq[i].val[NOUT-1:0]);
            end
          end else if (bus_rdata !== sbq[i].val[31:0]) begin
            errors++;
            $display("FAIL %s read 0x%h slot %0d actual=%h expected=%h", sbq[i].tag, bus_addr, slot, bus_rdata, sbq[i].val[31:0]);
          end
          sbq.delete(i);
        end else if (sbq[i].cyc < slot) begin
          errors++;
          $display("FAIL %s item for slot %0d never compared actual=none expected=%h", sbq[i].tag, sbq[i].cyc, sbq[i].val);
          sbq.delete(i);
        end
      end
      if (!got_irq && irq_o !== '0) begin
        errors++;
        $display("FAIL R10 stray pulse slot %0d actual=%h expected=0", slot, irq_o);
      end
    end
  end

  initial begin
    #(PER * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [NL-1:0] lines;
    lines = '0;
    idle(3);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(6'(a * 4), 32'h0, "R1");
      rd(6'(8'h20 + a * 4), 32'h0, "R1");
    end

    // R2 writable masks
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, 32'hFFFF_FFFF, "R2");
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, 32'hFFFF_FFFF, "R2");
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, 32'h007D_FFFF, "R2");
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, 32'h007D_FFFF, "R2");
    wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, 32'h0000_00FF, "R2");
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, 32'h0000_00FF, "R2");
    wr(6'h28, 32'hFFFF_FFFF); rd(6'h28, 32'h0000_0078, "R2");
    wr(6'h2C, 32'hFFFF_FFFF); rd(6'h2C, 32'h0000_0078, "R2");
    wr(6'h20, 0); wr(6'h24, 0); wr(6'h28, 0); wr(6'h2C, 0);
    wr(6'h04, 0); wr(6'h0C, 0); wr(6'h08, 0); rd(6'h08, 32'h0, "R2");

    // R3 direct lines
    wr(6'h10, 32'hFF82_0000); rd(6'h10, 32'h0, "R3");
    wr(6'h30, 32'h87); rd(6'h30, 32'h0, "R3");
    wr(6'h14, 32'hFF82_0000); rd(6'h14, 32'h0, "R3");
    wr(6'h08, 32'hFFFF_FFFF);
    lines[17] = 1; drive(lines); push(2, 1, 64'h0, "R3");
    idle(3); rd(6'h14, 32'h0, "R3"); rd(6'h10, 32'h0, "R3");
    lines[17] = 0; drive(lines);
    wr(6'h08, 0); wr(6'h00, 0); idle(2);

    // R4 rising, falling, both on line 1
    wr(6'h00, 32'h2); wr(6'h08, 32'h2);
    lines[1] = 1; drive(lines); push(2, 1, 64'h2, "R4");
    idle(2); rd(6'h14, 32'h2, "R4");
    wr(6'h14, 32'h2); rd(6'h14, 32'h0, "R9");
    lines[1] = 0; drive(lines); push(2, 1, 64'h0, "R4");
    idle(3); rd(6'h14, 32'h0, "R4");
    wr(6'h08, 0); wr(6'h0C, 32'h2);
    lines[1] = 1; drive(lines); push(2, 1, 64'h0, "R4");
    idle(3); rd(6'h14, 32'h0, "R4");
    lines[1] = 0; drive(lines); push(2, 1, 64'h2, "R4");
    idle(2); rd(6'h14, 32'h2, "R4"); wr(6'h14, 32'h2);
    wr(6'h08, 32'h2);
    lines[1] = 1; drive(lines); push(2, 1, 64'h2, "R4");
    idle(2); wr(6'h14, 32'h2);
    lines[1] = 0; drive(lines); push(2, 1, 64'h2, "R4");
    idle(2); rd(6'h14, 32'h2, "R4"); wr(6'h14, 32'h2);

    // R5 no select
    wr(6'h08, 0); wr(6'h0C, 0);
    lines[1] = 1; drive(lines); push(2, 1, 64'h0, "R5");
    idle(3);
    lines[1] = 0; drive(lines); push(2, 1, 64'h0, "R5");
    idle(3); rd(6'h14, 32'h0, "R5");

    // R6 masked edge dropped
    wr(6'h00, 0); wr(6'h08, 32'h2);
    lines[1] = 1; drive(lines); push(2, 1, 64'h0, "R6");
    idle(3); wr(6'h00, 32'h2); idle(2); rd(6'h14, 32'h0, "R6");
    lines[1] = 0; drive(lines); wr(6'h08, 0); wr(6'h00, 0); idle(2);

    // R7 software trigger, R10 no repeat while pending, R9 clear
    wr(6'h00, 32'h1); wr(6'h10, 0);
    wr(6'h10, 32'h1); push(1, 1, 64'h1, "R7");
    rd(6'h10, 32'h1, "R7"); rd(6'h14, 32'h1, "R7");
    wr(6'h10, 0); wr(6'h10, 32'h1); push(1, 1, 64'h0, "R10");
    rd(6'h14, 32'h1, "R10");
    wr(6'h14, 0); rd(6'h14, 32'h1, "R9");
    wr(6'h14, 32'h1); push(1, 1, 64'h0, "R9");
    rd(6'h14, 32'h0, "R9"); rd(6'h10, 32'h0, "R9");

    // R7 high bank line 35 -> output 31
    wr(6'h20, 32'h8); wr(6'h30, 32'h8); push(1, 1, 64'h8000_0000, "R7");
    rd(6'h30, 32'h8, "R7"); rd(6'h34, 32'h8, "R7");
    wr(6'h34, 32'h8); rd(6'h34, 32'h0, "R9"); rd(6'h30, 32'h0, "R9");
    wr(6'h20, 0);

    // R8 software trigger while masked
    wr(6'h00, 0); wr(6'h10, 0);
    wr(6'h10, 32'h1); push(1, 1, 64'h0, "R8");
    rd(6'h10, 32'h1, "R8"); rd(6'h14, 32'h0, "R8");
    wr(6'h00, 32'h1); idle(1); rd(6'h14, 32'h0, "R8");
    wr(6'h10, 0); wr(6'h00, 0);

    // R11 shared output for lines 5..9, line 10 on output 6
    wr(6'h00, 32'h7E0); wr(6'h08, 32'h7E0);
    for (int i = 5; i < 10; i++) begin
      lines[i] = 1; drive(lines); push(2, 1, 64'h20, "R11");
      idle(2); rd(6'h14, 32'h1 << i, "R11");
      wr(6'h14, 32'h1 << i);
      lines[i] = 0; drive(lines); idle(2);
    end
    lines[6:5] = 2'b11; drive(lines); push(2, 1, 64'h20, "R11");
    idle(2); rd(6'h14, 32'h60, "R11"); wr(6'h14, 32'h60);
    lines[6:5] = 2'b00; drive(lines); idle(2);
    lines[10] = 1; drive(lines); push(2, 1, 64'h40, "R11");
    idle(2); rd(6'h14, 32'h400, "R11"); wr(6'h14, 32'h400);
    lines[10] = 0; drive(lines);
    wr(6'h08, 0); wr(6'h00, 0); idle(2);

    // R12 clear and new pend in the same cycle
    wr(6'h00, 32'h1); wr(6'h08, 32'h1); wr(6'h10, 0);
    wr(6'h10, 32'h1); push(1, 1, 64'h1, "R12");
    lines[0] = 1; drive(lines);
    wr(6'h14, 32'h1); push(1, 1, 64'h1, "R12");
    rd(6'h14, 32'h1, "R12"); rd(6'h10, 32'h0, "R12");
    wr(6'h14, 32'h1); lines[0] = 0; drive(lines);
    wr(6'h08, 0); wr(6'h00, 0);

    idle(4);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule